// File: doc/BRIEF.md
# Tach Count Coherent Read Latch

This block sits between four fan tach measurement channels and an 8-bit register read port. Each channel supplies a 16-bit count that changes at any time. Software reads the count as two bytes and must read the low byte first. That read returns the low byte and, in the same cycle, copies the high byte of the same sample into a per-channel holding register. A later high-byte read then returns a byte that belongs with the low byte already read.

A mode input sets when the holding register stops being used. In hold mode (`mode_i = 0`) the held byte is returned on every high-byte read until the next low-byte read of that channel. In release mode (`mode_i = 1`) the held byte is returned once. After that, high-byte reads return the live count until the next low-byte read. Any address outside the channel map reads as zero.

Top module: `tach_pair_latch`

## Requirements
- R1: A low-byte read returns bits 7:0 of the addressed channel's count as sampled in the strobe cycle, on `rdata_o` one cycle after the strobe.
- R2: A low-byte read captures bits 15:8 of the same sample. The next high-byte read of that channel returns the captured byte even if the count has changed since.
- R3: With `mode_i = 0`, every high-byte read after a low-byte read returns the captured byte until the channel's next low-byte read.
- R4: With `mode_i = 1`, the first high-byte read after a low-byte read returns the captured byte. Later high-byte reads return live bits 15:8 of the count.
- R5: A high-byte read of a channel with no captured byte pending returns the live bits 15:8 of its count.
- R6: Channel k (k = 0..3) has its low byte at address 0x28 + 2k and its high byte at 0x29 + 2k.
- R7: A read of any address outside 0x28..0x2F returns 0x00 and leaves every channel's captured state unchanged.
- R8: Each channel has its own captured byte and pending flag. A read of one channel never changes what another channel returns.
- R9: Reset clears `rdata_o` to 0x00 and discards every captured byte, so the first high-byte read after reset returns the live value.
- R10: `rdata_o` keeps its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0: hold until the next low-byte read; 1: release after one high-byte read |
| cnt_i | input | 64 | Live counts; channel k in bits 16k+15:16k |
| rd_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 8 | Read address, sampled with `rd_i` |
| rdata_o | output | 8 | Read data, valid the cycle after the strobe |

## Verification
A corrupted pending flag has two possible symptoms. A high-byte read that should return live data returns an old byte, or a read that should return the captured byte returns the live one. Either shows on `rdata_o` one cycle after that read. So the bench changes the count between every low-byte read and the high-byte read that follows it, and every high byte it expects is different from the live one. It also runs back-to-back high-byte reads in both modes, reads across channels, and reads of unmapped addresses placed between a low-byte read and its high-byte read. These expose a release or a capture that happens when it should not.

// File: rtl/tach_pkg.sv
package tach_pkg;
  localparam int unsigned NUM_CH    = 4;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned CNT_W     = 2 * BYTE_W;
  localparam int unsigned ADDR_W    = 8;
  localparam logic [7:0]  BASE_ADDR = 8'h28;

  typedef enum logic {
    REL_ON_LOW  = 1'b0,
    REL_ON_READ = 1'b1
  } rel_mode_e;
endpackage

// File: rtl/tach_addr_dec.sv
module tach_addr_dec #(
  parameter int unsigned  ADDR_W    = 8,
  parameter int unsigned  NUM_CH    = 4,
  parameter logic [ADDR_W-1:0] BASE = '0,
  localparam int unsigned CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              hi_o,
  output logic [CH_W-1:0]   ch_o
);
  logic [ADDR_W-1:0] off;

  // addresses below BASE wrap to large offsets and miss
  assign off   = addr_i - BASE;
  assign hit_o = off < ADDR_W'(2 * NUM_CH);
  assign hi_o  = off[0];
  assign ch_o  = CH_W'(off >> 1);
endmodule

// File: rtl/tach_hold_ch.sv
module tach_hold_ch #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              lo_rd_i,
  input  logic              hi_rd_i,
  input  logic [BYTE_W-1:0] hi_live_i,
  output logic [BYTE_W-1:0] hi_o
);
  logic [BYTE_W-1:0] hold_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      pend_q <= 1'b0;
    end else if (lo_rd_i) begin
      hold_q <= hi_live_i;
      pend_q <= 1'b1;
    end else if (hi_rd_i && mode_i) begin
      pend_q <= 1'b0;
    end
  end

  assign hi_o = pend_q ? hold_q : hi_live_i;
endmodule

// File: rtl/tach_pair_latch.sv
module tach_pair_latch
  import tach_pkg::*;
#(
  parameter int unsigned     N_CH   = NUM_CH,
  parameter int unsigned     BW     = BYTE_W,
  parameter int unsigned     AW     = ADDR_W,
  parameter logic [AW-1:0]   BASE   = AW'(BASE_ADDR),
  localparam int unsigned    CW     = 2 * BW,
  localparam int unsigned    CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic [N_CH*CW-1:0] cnt_i,
  input  logic             rd_i,
  input  logic [AW-1:0]    addr_i,
  output logic [BW-1:0]    rdata_o
);
  logic            hit, hi;
  logic [CH_W-1:0] ch;
  logic [BW-1:0]   lo_byte [N_CH];
  logic [BW-1:0]   hi_byte [N_CH];
  logic [BW-1:0]   rdata_d;

  tach_addr_dec #(.ADDR_W(AW), .NUM_CH(N_CH), .BASE(BASE)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit),
    .hi_o   (hi),
    .ch_o   (ch)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic sel;
    assign sel        = rd_i && hit && (ch == CH_W'(k));
    assign lo_byte[k] = cnt_i[k*CW +: BW];

    tach_hold_ch #(.BYTE_W(BW)) u_hold (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (mode_i),
      .lo_rd_i   (sel && !hi),
      .hi_rd_i   (sel && hi),
      .hi_live_i (cnt_i[k*CW+BW +: BW]),
      .hi_o      (hi_byte[k])
    );
  end

  always_comb begin
    rdata_d = '0;
    if (hit) rdata_d = hi ? hi_byte[ch] : lo_byte[ch];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rdata_d;
  end
endmodule

// File: rtl/tach_pair_latch_chk.sv
module tach_pair_latch_chk #(
  parameter int unsigned   N_CH = 4,
  parameter int unsigned   BW   = 8,
  parameter int unsigned   AW   = 8,
  parameter logic [AW-1:0] BASE = '0,
  localparam int unsigned  CW   = 2 * BW
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mode_i,
  input logic [N_CH*CW-1:0] cnt_i,
  input logic               rd_i,
  input logic [AW-1:0]      addr_i,
  input logic [BW-1:0]      rdata_o
);
  logic [AW-1:0] off;
  logic          is_lo, is_hi;
  logic [BW-1:0] exp_lo, exp_hi;

  assign off = addr_i - BASE;

  always_comb begin
    is_lo  = 1'b0;
    is_hi  = 1'b0;
    exp_lo = '0;
    exp_hi = '0;
    for (int k = 0; k < N_CH; k++) begin
      if (off == AW'(2*k)) begin
        is_lo  = 1'b1;
        exp_lo = cnt_i[k*CW +: BW];
      end
      if (off == AW'(2*k+1)) begin
        is_hi  = 1'b1;
        exp_hi = cnt_i[k*CW+BW +: BW];
      end
    end
  end

  a_r1_low_byte_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && is_lo |=> rdata_o == $past(exp_lo));

  a_r7_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !is_lo && !is_hi |=> rdata_o == '0);

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  // back-to-back high reads of one channel in release mode: second is live
  a_r4_second_hi_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && mode_i && is_hi && $past(rd_i) && $past(mode_i) &&
    ($past(addr_i) == addr_i) |=> rdata_o == $past(exp_hi));
endmodule

bind tach_pair_latch tach_pair_latch_chk #(
  .N_CH(N_CH), .BW(BW), .AW(AW), .BASE(BASE)
) u_chk (.*);

// File: tb/sim_tach_pair_latch.sv
module sim_tach_pair_latch;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b0;
  logic [63:0] cnt_i = '0;
  logic        rd_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [7:0]  rdata_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10ns clk_i = ~clk_i;

  tach_pair_latch u0 (.*);

  // {mode, base count, address, expected}; channel k count = base + k*0x0100
  localparam int NV = 17;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 16'h1234, 8'h29, 8'h12},  // R5 unlatched high is live
    {1'b0, 16'h1234, 8'h28, 8'h34},  // R1 low byte
    {1'b0, 16'h5678, 8'h29, 8'h12},  // R2 captured high
    {1'b0, 16'h9ABC, 8'h29, 8'h12},  // R3 still held
    {1'b0, 16'h9ABC, 8'h2B, 8'h9B},  // R8 ch1 unaffected, live
    {1'b0, 16'h9ABC, 8'h30, 8'h00},  // R7 above map
    {1'b0, 16'h9ABC, 8'h27, 8'h00},  // R7 below map
    {1'b1, 16'h9ABC, 8'h2C, 8'hBC},  // R6 ch2 low
    {1'b1, 16'h1111, 8'h2D, 8'h9C},  // R4 first high held
    {1'b1, 16'h2222, 8'h2D, 8'h24},  // R4 then live
    {1'b1, 16'h2222, 8'h29, 8'h12},  // R8 ch0 still pending
    {1'b1, 16'h3333, 8'h29, 8'h33},  // R4 ch0 released
    {1'b0, 16'h4455, 8'h2E, 8'h55},  // R6 ch3 low
    {1'b0, 16'h0000, 8'h2F, 8'h47},  // R2 ch3 captured
    {1'b0, 16'hFFFF, 8'h2F, 8'h47},  // R3 repeated
    {1'b0, 16'h00FF, 8'hFF, 8'h00},  // R7 unmapped
    {1'b0, 16'h00FF, 8'h2F, 8'h47}   // R7 no state change
  };

  task automatic set_cnt(input logic [15:0] base);
    for (int k = 0; k < 4; k++) cnt_i[k*16 +: 16] = base + 16'(k * 256);
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata_o=%02h expected %02h", req, got, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] a);
    @(negedge clk_i);
    addr_i = a;
    rd_i   = 1'b1;
    @(negedge clk_i);
    rd_i   = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 reset value", rdata_o, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      mode_i = VEC[i][32];
      set_cnt(VEC[i][31:16]);
      do_read(VEC[i][15:8]);
      check($sformatf("vec %0d R1-R8", i), rdata_o, VEC[i][7:0]);
    end

    // R10: idle cycles with changing counts keep the last read data
    for (int i = 0; i < 3; i++) begin
      set_cnt(16'hA5A5 + 16'(i));
      @(negedge clk_i);
      check("R10 idle hold", rdata_o, 8'h47);
    end

    // R9: reset drops a pending capture on ch1
    mode_i = 1'b0;
    set_cnt(16'h0000);
    do_read(8'h2A);
    check("R1 ch1 low", rdata_o, 8'h00);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R9 reset clears data", rdata_o, 8'h00);
    rst_ni = 1'b1;
    set_cnt(16'h5000);
    do_read(8'h2B);
    check("R9 capture discarded", rdata_o, 8'h51);

    // R2 with mode 1: capture survives count change
    mode_i = 1'b1;
    set_cnt(16'hC3D4);
    do_read(8'h2A);
    check("R1 ch1 low mode1", rdata_o, 8'hD4);
    set_cnt(16'h0000);
    do_read(8'h2B);
    check("R2 mode1 captured", rdata_o, 8'hC4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule